// File: doc/BRIEF.md
# Chainable Integrator Switch Sequencer

This block is the digital control core of a multi-channel integrating light sensor. A single serial bit, sampled on the rising clock edge, walks through a chain of rising-edge storage stages. Each stage position drives the analog switches directly. The first position connects channel 1's integrator to the shared analog output. The next position hands the output to channel 2 and shorts channel 1's integration capacitor. The position after that shorts channel 2's capacitor, and releasing it restarts channel 2. Releasing each short restarts integration on its channel.

A falling-edge output stage copies the stage that feeds the last output-select. Its output drives the serial input of the next sensor in a daisy chain. Because it updates half a cycle early, the next device captures the bit on its own rising edge one clock after this device's last read-out slot. An active-low asynchronous power-down input clears every register. Until the first high bit has passed through, the integrators run freely.

The channel count is a parameter `NCH`, with a default of 2. For any value, stage j+1 drives output-select j and stage j+2 drives integrator clear j.

Top module: `intsw_seq`

## Requirements
- R1: While `pd_n` is low, every register is cleared: `sel`, `clr` and `sdo` are 0 and `hiz` is 1, whatever `sdi` and `clk` do. Asserting `pd_n` takes effect without a clock edge.
- R2: A 1 on `sdi` sampled at rising edge k sets `sel[0]` to 1 for the clock period that follows edge k.
- R3: The bit sampled at edge k appears on `sel[1]` and on `clr[0]` for the period after edge k+1. At that edge, `sel[0]` drops for an isolated bit.
- R4: For every channel j, `clr[j]` in the period after edge k+1 equals `sel[j]` in the period after edge k. With two channels, `clr[1]` carries the bit sampled at edge k during the period after edge k+2.
- R5: `sdo` changes only on falling clock edges. After the falling edge that follows rising edge k+1, it carries the bit sampled at rising edge k, so a chained device samples that bit at edge k+2.
- R6: `hiz` is 1 exactly when no bit of `sel` is 1.
- R7: Each switching state lasts one full clock period. Consecutive 1 bits on `sdi` shift through without merging or loss, and the outputs follow the sampled history bit for bit.
- R8: The same mapping holds for `NCH` channels. Bit j of `sel` carries the bit sampled j edges earlier than the latest one. Bit j of `clr` carries the bit sampled j+1 edges earlier. `sdo` carries the bit sampled NCH-1 edges earlier than the latest, updated on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock; storage stages use the rising edge, the chain output uses the falling edge |
| pd_n | input | 1 | Asynchronous power-down clear, active low |
| sdi | input | 1 | Serial start bit from the host or the previous device |
| sel | output | NCH | Output-select switch enables, bit j for channel j+1 |
| clr | output | NCH | Integrator reset switch enables, bit j for channel j+1 |
| sdo | output | 1 | Serial bit to the next device in the chain |
| hiz | output | 1 | Analog output high-impedance request |

## Verification
The bench builds two copies of the block from one serial stream. One uses the default of two channels. The other uses three channels, which brings the general mapping of R8 within reach: the longer stage chain, the shifted `sdo` tap, and a third output-select and clear. A per-cycle history of sampled bits predicts every output. The bench drives isolated bits, back-to-back bits, a periodic start pattern, a pseudo-random stream, and a power-down applied in the middle of a read-out.

// File: rtl/intsw_pkg.sv
package intsw_pkg;

    // default number of integrating channels per sensor
    localparam int unsigned CHAN_DEF = 2;

    // number of rising-edge stages needed to sequence nch channels
    function automatic int unsigned stage_count(int unsigned nch);
        return nch + 1;
    endfunction

endpackage

// File: rtl/intsw_rise_shift.sv
module intsw_rise_shift #(
    parameter int unsigned DEPTH = 3
) (
    input  logic             clk,
    input  logic             pd_n,
    input  logic             sdi,
    output logic [DEPTH-1:0] taps
);
    typedef struct packed {
        logic [DEPTH-1:0] stg;
    } rs_state_t;

    rs_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.stg = {s_q.stg[DEPTH-2:0], sdi};
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign taps = s_q.stg;
endmodule

// File: rtl/intsw_fall_stage.sv
module intsw_fall_stage (
    input  logic clk,
    input  logic pd_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic chain;
    } fs_state_t;

    fs_state_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.chain = din;
    end

    always_ff @(negedge clk or negedge pd_n) begin
        if (!pd_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout = f_q.chain;
endmodule

// File: rtl/intsw_tap_decode.sv
module intsw_tap_decode #(
    parameter int unsigned NCH = 2,
    localparam int unsigned DEPTH = NCH + 1
) (
    input  logic [DEPTH-1:0] taps,
    output logic [NCH-1:0]   sel,
    output logic [NCH-1:0]   clr,
    output logic             hiz
);
    // stage j+1 selects channel j onto the output, stage j+2 shorts it
    for (genvar j = 0; j < NCH; j++) begin : g_chan
        assign sel[j] = taps[j];
        assign clr[j] = taps[j+1];
    end

    assign hiz = ~|sel;
endmodule

// File: rtl/intsw_seq.sv
module intsw_seq
    import intsw_pkg::*;
#(
    parameter int unsigned NCH = CHAN_DEF
) (
    input  logic           clk,
    input  logic           pd_n,
    input  logic           sdi,
    output logic [NCH-1:0] sel,
    output logic [NCH-1:0] clr,
    output logic           sdo,
    output logic           hiz
);
    localparam int unsigned DEPTH = stage_count(NCH);

    logic [DEPTH-1:0] taps;

    intsw_rise_shift #(.DEPTH(DEPTH)) u_shift (
        .clk  (clk),
        .pd_n (pd_n),
        .sdi  (sdi),
        .taps (taps)
    );

    // last output-select stage feeds the half-cycle-early chain output
    intsw_fall_stage u_fall (
        .clk  (clk),
        .pd_n (pd_n),
        .din  (taps[NCH-1]),
        .dout (sdo)
    );

    intsw_tap_decode #(.NCH(NCH)) u_dec (
        .taps (taps),
        .sel  (sel),
        .clr  (clr),
        .hiz  (hiz)
    );
endmodule

// File: rtl/intsw_seq_chk.sv
module intsw_seq_chk #(
    parameter int unsigned NCH = 2
) (
    input logic           clk,
    input logic           pd_n,
    input logic           sdi,
    input logic [NCH-1:0] sel,
    input logic [NCH-1:0] clr,
    input logic           sdo,
    input logic           hiz
);
    // edges seen since power-down released, saturating
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_cleared_r1: assert property (@(posedge clk) disable iff (pd_n)
        1'b1 |-> (sel == '0 && clr == '0 && sdo == 1'b0 && hiz == 1'b1));

    p_first_sel_r2: assert property (@(posedge clk) disable iff (!pd_n)
        (age_q != 2'd0) |-> (sel[0] == $past(sdi)));

    p_second_slot_r3: assert property (@(posedge clk) disable iff (!pd_n)
        (age_q != 2'd0) |-> (sel[1] == $past(sel[0]) && clr[0] == $past(sel[0])));

    for (genvar j = 0; j < NCH; j++) begin : g_clr
        p_clr_follows_r4: assert property (@(posedge clk) disable iff (!pd_n)
            (age_q != 2'd0) |-> (clr[j] == $past(sel[j])));
    end

    p_chain_tap_r5: assert property (@(posedge clk) disable iff (!pd_n)
        (age_q != 2'd0) |-> (sdo == sel[NCH-1]));

    p_hiz_set_r6: assert property (@(posedge clk) disable iff (!pd_n)
        hiz |-> (sel == '0));

    p_hiz_clr_r6: assert property (@(posedge clk) disable iff (!pd_n)
        !hiz |-> ($countones(sel) >= 1));
endmodule

bind intsw_seq intsw_seq_chk #(.NCH(NCH)) u_chk (
    .clk  (clk),
    .pd_n (pd_n),
    .sdi  (sdi),
    .sel  (sel),
    .clr  (clr),
    .sdo  (sdo),
    .hiz  (hiz)
);

// File: tb/sim_intsw_seq.sv
`timescale 1ns/1ps
module sim_intsw_seq;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic pd_n;
    logic sdi;

    logic [1:0] sel0, clr0;
    logic       sdo0, hiz0;
    logic [2:0] sel1, clr1;
    logic       sdo1, hiz1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit hist[$];

    always #(PERIOD/2) clk = ~clk;

    intsw_seq #(.NCH(2)) u0 (
        .clk(clk), .pd_n(pd_n), .sdi(sdi),
        .sel(sel0), .clr(clr0), .sdo(sdo0), .hiz(hiz0)
    );

    intsw_seq #(.NCH(3)) u1 (
        .clk(clk), .pd_n(pd_n), .sdi(sdi),
        .sel(sel1), .clr(clr1), .sdo(sdo1), .hiz(hiz1)
    );

    // reference: history of sampled bits, newest at index 0
    always @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            hist.delete();
        end else begin
            hist.push_front(sdi);
            if (hist.size() > 8) void'(hist.pop_back());
        end
    end

    function automatic bit bk(int i);
        if (i < hist.size()) return hist[i];
        return 1'b0;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic check_comb();
        int e0s, e0c, e1s, e1c;
        e0s = 0; e0c = 0; e1s = 0; e1c = 0;
        for (int j = 0; j < 2; j++) begin
            e0s |= int'(bk(j)) << j;
            e0c |= int'(bk(j+1)) << j;
        end
        for (int j = 0; j < 3; j++) begin
            e1s |= int'(bk(j)) << j;
            e1c |= int'(bk(j+1)) << j;
        end
        chk("R2/R3 sel nch2", int'(sel0), e0s);
        chk("R3/R4 clr nch2", int'(clr0), e0c);
        chk("R6 hiz nch2", int'(hiz0), int'(e0s == 0));
        chk("R8 sel nch3", int'(sel1), e1s);
        chk("R8 clr nch3", int'(clr1), e1c);
        chk("R6 hiz nch3", int'(hiz1), int'(e1s == 0));
        // before the falling edge sdo still holds the older bit
        chk("R5 sdo before fall nch2", int'(sdo0), int'(bk(2)));
        chk("R8 sdo before fall nch3", int'(sdo1), int'(bk(3)));
    endtask

    task automatic cycle(bit nxt);
        @(posedge clk);
        #2;
        check_comb();
        #1 sdi = nxt;
        @(negedge clk);
        #2;
        chk("R5 sdo after fall nch2", int'(sdo0), int'(bk(1)));
        chk("R8 sdo after fall nch3", int'(sdo1), int'(bk(2)));
    endtask

    task automatic check_reset(string tag);
        chk({tag, " R1 sel"}, int'({sel1, sel0}), 0);
        chk({tag, " R1 clr"}, int'({clr1, clr0}), 0);
        chk({tag, " R1 sdo"}, int'({sdo1, sdo0}), 0);
        chk({tag, " R1 hiz"}, int'({hiz1, hiz0}), 3);
    endtask

    initial begin
        logic [7:0] lfsr;
        pd_n = 1'b0;
        sdi  = 1'b1;
        // R1: input toggling under power-down has no effect
        repeat (3) @(posedge clk);
        #2 check_reset("initial");
        @(negedge clk);
        #2 check_reset("initial falling");
        sdi = 1'b0;
        @(posedge clk);
        #3 pd_n = 1'b1;

        // R2 R3 R4 R5: isolated bit
        cycle(1'b1);
        repeat (6) cycle(1'b0);

        // R7: back-to-back bits
        cycle(1'b1);
        cycle(1'b1);
        cycle(1'b1);
        repeat (6) cycle(1'b0);

        // periodic start every four cycles, as in continuous chained use
        for (int r = 0; r < 6; r++) begin
            cycle(1'b1);
            repeat (3) cycle(1'b0);
        end

        // pseudo-random stream
        lfsr = 8'hA5;
        for (int i = 0; i < 60; i++) begin
            cycle(lfsr[0]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        // R1: power-down in the middle of a read-out
        cycle(1'b1);
        cycle(1'b1);
        cycle(1'b0);
        @(posedge clk);
        #1 pd_n = 1'b0;
        #1 check_reset("mid-run");
        sdi = 1'b1;
        @(posedge clk);
        #2 check_reset("mid-run clocked");
        sdi = 1'b0;
        @(posedge clk);
        #3 pd_n = 1'b1;
        cycle(1'b1);
        repeat (5) cycle(1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired t=%0t actual=running expected=finished", $time);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule